// File: doc/BRIEF.md
# Bit-Field Extract and Inject Unit

This unit moves a bit field between two 16-bit accumulator words, A0 and A1. A control byte packs two 4-bit codes: a shift position and a field width. The extract operation pulls the field out of A0 and writes it, right-justified, into A1. The inject operation replaces the field in A0 with the low-order bits of A1.

Both operations use one datapath slice. The slice rotates a word left and then zeroes a number of low bits and a number of high bits. A small decoder turns the shift and width codes into the rotate amount and the two mask counts for each operation. Inject runs an all-ones word through a second copy of the slice to get the mask that clears the field in A0.

The results are registered. A done pulse marks each accepted request one cycle after its valid strobe. A request can be accepted on every cycle.

Top module: `bitfield_unit`

## Requirements
- R1: The shift position s is `ctrl_i[3:0]` and the width code w is `ctrl_i[7:4]`. The effective field width W is w, except that a width code of 0 means W = 16.
- R2: `op_i` = 0 selects extract and `op_i` = 1 selects inject.
- R3: After an extract, `a1_o` holds the low W bits of A0 rotated right by s, and every bit above those W bits is zero. When s + W > 16, the field wraps around into the low bits of A0.
- R4: An extract leaves A0 unchanged: `a0_o` equals the `a0_i` that was sampled.
- R5: After an inject, `a0_o` holds A0 with every bit of the field F replaced by the matching bit of A1 shifted left by s. F is bit positions s through min(s + W − 1, 15).
- R6: An inject leaves A1 unchanged: `a1_o` equals the `a1_i` that was sampled.
- R7: When s + W > 16, an inject touches only bits s through 15 of A0. Bits below s are kept and nothing wraps around.
- R8: `done_o` is high in exactly the cycles that follow a cycle with `valid_i` high. Back-to-back requests are each accepted and each produce a result.
- R9: While `valid_i` is low, `a0_o` and `a1_o` keep their values, whatever the other inputs do.
- R10: During synchronous reset (`rst_n` low at a clock edge), `a0_o`, `a1_o` and `done_o` become 0, and any request is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Request strobe; the inputs are sampled when it is high |
| op_i | input | 1 | 0 = extract, 1 = inject |
| ctrl_i | input | 8 | [7:4] width code, [3:0] shift position |
| a0_i | input | 16 | Accumulator word A0 |
| a1_i | input | 16 | Accumulator word A1 |
| a0_o | output | 16 | Updated A0 |
| a1_o | output | 16 | Updated A1 |
| done_o | output | 1 | Pulses one cycle after each accepted request |

## Verification
Two things can happen in the same cycle: the done pulse and updated words of one request appear while the next request is being captured. The bench provokes this by holding the valid strobe high over runs of cycles with alternating extract and inject and with changing control bytes. It also mixes in idle cycles during which the inputs keep changing. A behavioural per-bit model in the bench predicts both words and the done flag for every clock. Each output is compared after every edge, so if one request's result leaks into the next, or a word changes while the unit is idle, the comparison fails.

// File: rtl/bfu_pkg.sv
// Package for the bit-field unit.
// Holds the operation encoding and the default word width.
// Assumes the word width is a power of two.
package bfu_pkg;
    localparam int unsigned BFU_WORD_W = 16;

    typedef enum logic {
        OP_EXTRACT = 1'b0,
        OP_INJECT  = 1'b1
    } bfu_op_e;
endpackage

// File: rtl/bfu_decode.sv
// Control decoder.
// Turns the packed shift and width codes into a left-rotate amount, a
// high-side mask count and a low-side mask count for the chosen operation.
// Assumes WORD_W is a power of two, so the rotate amount wraps naturally.
module bfu_decode
    import bfu_pkg::*;
#(
    parameter int unsigned WORD_W = BFU_WORD_W,
    localparam int unsigned NIB_W = $clog2(WORD_W),
    localparam int unsigned CNT_W = NIB_W + 1
) (
    input  bfu_op_e          op,
    input  logic [NIB_W-1:0] shift_c,
    input  logic [NIB_W-1:0] width_c,
    output logic [NIB_W-1:0] rot_amt,
    output logic [CNT_W-1:0] hi_cnt,
    output logic [CNT_W-1:0] lo_cnt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic [CNT_W-1:0] w_eff;
    logic [CNT_W:0]   span;

    // Effective width: a zero code means the whole word.
    always_comb begin
        w_eff = (width_c == '0) ? FULL : {1'b0, width_c};
        span  = {1'b0, w_eff} + {2'b00, shift_c};
    end

    // Per-operation rotate amount and mask counts.
    always_comb begin
        if (op == OP_EXTRACT) begin
            rot_amt = NIB_W'(0) - shift_c;
            hi_cnt  = FULL - w_eff;
            lo_cnt  = '0;
        end else begin
            rot_amt = shift_c;
            lo_cnt  = {1'b0, shift_c};
            if (span >= {1'b0, FULL})
                hi_cnt = '0;
            else
                hi_cnt = FULL - span[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/bfu_rotmask.sv
// Rotate-and-double-mask slice.
// Rotates the input left by rot_amt, then zeroes the lo_cnt lowest bits
// and the hi_cnt highest bits. Mask counts may be as large as WORD_W.
module bfu_rotmask #(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned NIB_W = $clog2(WORD_W),
    localparam int unsigned CNT_W = NIB_W + 1
) (
    input  logic [WORD_W-1:0] din,
    input  logic [NIB_W-1:0]  rot_amt,
    input  logic [CNT_W-1:0]  hi_cnt,
    input  logic [CNT_W-1:0]  lo_cnt,
    output logic [WORD_W-1:0] dout
);
    logic [WORD_W-1:0] stage [0:NIB_W];
    logic [WORD_W-1:0] keep;

    assign stage[0] = din;

    // Logarithmic rotator: stage k rotates by 2**k when its bit is set.
    for (genvar k = 0; k < NIB_W; k++) begin : g_rot
        localparam int unsigned AMT = 1 << k;
        assign stage[k+1] = rot_amt[k]
            ? {stage[k][WORD_W-1-AMT:0], stage[k][WORD_W-1:WORD_W-AMT]}
            : stage[k];
    end

    // Per-bit keep: the bit lies above the low mask and below the high mask.
    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
        localparam logic [CNT_W-1:0] POS = CNT_W'(i);
        localparam logic [CNT_W-1:0] TOP = CNT_W'(WORD_W - 1 - i);
        assign keep[i] = (POS >= lo_cnt) && (hi_cnt <= TOP);
    end

    assign dout = stage[NIB_W] & keep;
endmodule

// File: rtl/bitfield_unit.sv
// Bit-field extract/inject unit (top).
// Extract: A1 <- field of A0, right-justified; A0 is kept.
// Inject: the field of A0 <- low bits of A1; A1 is kept.
// One rotate/mask slice handles the data, and a second slice with the same
// settings builds the inject clearing mask from an all-ones word.
// Results and the done flag are registered; synchronous active-low reset.
module bitfield_unit
    import bfu_pkg::*;
#(
    parameter int unsigned WORD_W = BFU_WORD_W,
    localparam int unsigned NIB_W = $clog2(WORD_W),
    localparam int unsigned CNT_W = NIB_W + 1,
    localparam int unsigned CTRL_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              op_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [WORD_W-1:0] a0_i,
    input  logic [WORD_W-1:0] a1_i,
    output logic [WORD_W-1:0] a0_o,
    output logic [WORD_W-1:0] a1_o,
    output logic              done_o
);
    bfu_op_e           op;
    logic [NIB_W-1:0]  rot_amt;
    logic [CNT_W-1:0]  hi_cnt;
    logic [CNT_W-1:0]  lo_cnt;
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] placed;
    logic [WORD_W-1:0] fmask;
    logic [WORD_W-1:0] a0_nxt;
    logic [WORD_W-1:0] a1_nxt;

    assign op = bfu_op_e'(op_i);

    bfu_decode #(.WORD_W(WORD_W)) dec_i (
        .op      (op),
        .shift_c (ctrl_i[NIB_W-1:0]),
        .width_c (ctrl_i[CTRL_W-1:NIB_W]),
        .rot_amt (rot_amt),
        .hi_cnt  (hi_cnt),
        .lo_cnt  (lo_cnt)
    );

    // Source word: A0 is the field source for extract, A1 for inject.
    always_comb src = (op == OP_EXTRACT) ? a0_i : a1_i;

    bfu_rotmask #(.WORD_W(WORD_W)) data_i (
        .din     (src),
        .rot_amt (rot_amt),
        .hi_cnt  (hi_cnt),
        .lo_cnt  (lo_cnt),
        .dout    (placed)
    );

    bfu_rotmask #(.WORD_W(WORD_W)) mask_i (
        .din     ({WORD_W{1'b1}}),
        .rot_amt (rot_amt),
        .hi_cnt  (hi_cnt),
        .lo_cnt  (lo_cnt),
        .dout    (fmask)
    );

    // Next-state words for the selected operation.
    always_comb begin
        if (op == OP_EXTRACT) begin
            a0_nxt = a0_i;
            a1_nxt = placed;
        end else begin
            a0_nxt = (a0_i & ~fmask) | placed;
            a1_nxt = a1_i;
        end
    end

    // Result registers: load on valid, hold otherwise; done follows valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a0_o   <= '0;
            a1_o   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= valid_i;
            if (valid_i) begin
                a0_o <= a0_nxt;
                a1_o <= a1_nxt;
            end
        end
    end
endmodule

// File: rtl/bitfield_unit_chk.sv
// Assertion checker for bitfield_unit, attached with bind.
// It computes the field span from the request by shifting, independently of
// the rotate/mask slices, and checks output behaviour one cycle later.
module bitfield_unit_chk #(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned NIB_W = $clog2(WORD_W),
    localparam int unsigned CTRL_W = 2 * NIB_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic              op_i,
    input logic [CTRL_W-1:0] ctrl_i,
    input logic [WORD_W-1:0] a0_i,
    input logic [WORD_W-1:0] a1_i,
    input logic [WORD_W-1:0] a0_o,
    input logic [WORD_W-1:0] a1_o,
    input logic              done_o
);
    logic [NIB_W-1:0]  sh;
    logic [NIB_W-1:0]  wc;
    logic [WORD_W-1:0] low_ones;
    logic [WORD_W-1:0] span;

    // Field span worked out by shifting the low-order ones up by s.
    always_comb begin
        sh       = ctrl_i[NIB_W-1:0];
        wc       = ctrl_i[CTRL_W-1:NIB_W];
        low_ones = (wc == '0) ? '1 : ((WORD_W'(1) << wc) - WORD_W'(1));
        span     = low_ones << sh;
    end

    p_done_after_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);
    p_no_stray_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !done_o);
    p_extract_keeps_a0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i) |=> (a0_o == $past(a0_i)));
    p_inject_keeps_a1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i) |=> (a1_o == $past(a1_i)));
    p_extract_high_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i) |=> ((a1_o & ~$past(low_ones)) == '0));
    p_inject_outside_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i) |=> (((a0_o ^ $past(a0_i)) & ~$past(span)) == '0));
    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(a0_o) && $stable(a1_o)));
endmodule

bind bitfield_unit bitfield_unit_chk #(.WORD_W(WORD_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .op_i    (op_i),
    .ctrl_i  (ctrl_i),
    .a0_i    (a0_i),
    .a1_i    (a1_i),
    .a0_o    (a0_o),
    .a1_o    (a1_o),
    .done_o  (done_o)
);

// File: tb/bitfield_unit_tb_top.sv
// Bench for bitfield_unit. A bit-by-bit reference model predicts the outputs
// and every clock is compared.
module bitfield_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        op_i = 1'b0;
    logic [7:0]  ctrl_i = '0;
    logic [15:0] a0_i = '0;
    logic [15:0] a1_i = '0;
    logic [15:0] a0_o;
    logic [15:0] a1_o;
    logic        done_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] exp_a0 = '0;
    logic [15:0] exp_a1 = '0;
    logic        exp_done = 1'b0;

    always #2 clk = ~clk;

    bitfield_unit dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .ctrl_i(ctrl_i), .a0_i(a0_i), .a1_i(a1_i),
        .a0_o(a0_o), .a1_o(a1_o), .done_o(done_o)
    );

    function automatic int eff_w(input logic [7:0] c);
        return (c[7:4] == 0) ? 16 : int'(c[7:4]);
    endfunction

    // Extract model: result bit i comes from A0 bit (s+i) mod 16.
    function automatic logic [15:0] m_extract(input logic [7:0] c, input logic [15:0] x);
        logic [15:0] r = '0;
        int s = int'(c[3:0]);
        for (int i = 0; i < eff_w(c); i++) r[i] = x[(s + i) % 16];
        return r;
    endfunction

    // Inject model: A0 bit s+i takes A1 bit i while s+i stays below 16.
    function automatic logic [15:0] m_inject(input logic [7:0] c, input logic [15:0] x0,
                                             input logic [15:0] x1);
        logic [15:0] r = x0;
        int s = int'(c[3:0]);
        for (int i = 0; i < eff_w(c); i++)
            if (s + i < 16) r[s + i] = x1[i];
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: apply at negedge, predict, compare at the next negedge.
    task automatic step(input logic v, input logic op, input logic [7:0] c,
                        input logic [15:0] x0, input logic [15:0] x1, input string tag);
        string t0, t1;
        valid_i = v; op_i = op; ctrl_i = c; a0_i = x0; a1_i = x1;
        if (v) begin
            exp_a0 = op ? m_inject(c, x0, x1) : x0;
            exp_a1 = op ? x1 : m_extract(c, x0);
            t0 = op ? "R5" : "R4";
            t1 = op ? "R6" : "R3";
        end else begin
            t0 = "R9";
            t1 = "R9";
        end
        exp_done = v;
        @(negedge clk);
        chk({tag, " ", t0}, "a0_o", a0_o, exp_a0);
        chk({tag, " ", t1}, "a1_o", a1_o, exp_a1);
        chk("R8", "done_o", {15'd0, done_o}, {15'd0, exp_done});
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset wins over a live request.
        @(negedge clk);
        valid_i = 1'b1; op_i = 1'b1; ctrl_i = 8'h00; a0_i = 16'hFFFF; a1_i = 16'h5A5A;
        @(negedge clk);
        @(negedge clk);
        chk("R10", "a0_o", a0_o, 16'h0000);
        chk("R10", "a1_o", a1_o, 16'h0000);
        chk("R10", "done_o", {15'd0, done_o}, 16'h0000);
        rst_n = 1'b1;
        valid_i = 1'b0;
        exp_a0 = '0; exp_a1 = '0; exp_done = 1'b0;
        step(0, 0, 8'h00, 16'h1234, 16'h4321, "R10");

        // Directed extract cases (R1 width code 0, R3 wrap-around).
        step(1, 0, 8'h44, 16'hABCD, 16'h0000, "R3");
        step(1, 0, 8'h00, 16'h1234, 16'hFFFF, "R1");
        step(1, 0, 8'h08, 16'h1234, 16'h0000, "R1");
        step(1, 0, 8'h8C, 16'hF00F, 16'h0000, "R3");
        step(1, 0, 8'h1F, 16'h8000, 16'hFFFF, "R3");
        // Directed inject cases (R7 truncation at bit 15).
        step(1, 1, 8'h44, 16'hFFFF, 16'h0005, "R5");
        step(1, 1, 8'h8C, 16'h0000, 16'hFFFF, "R7");
        step(1, 1, 8'h0F, 16'h0000, 16'hFFFF, "R7");
        step(1, 1, 8'h00, 16'hAAAA, 16'h1357, "R1");
        step(1, 1, 8'h10, 16'hFFFE, 16'h0001, "R5");
        // R2: same data under each operation code.
        step(1, 0, 8'h36, 16'hC3A5, 16'h0F0F, "R2");
        step(1, 1, 8'h36, 16'hC3A5, 16'h0F0F, "R2");
        // R9: idle while the inputs move.
        step(0, 1, 8'hFF, 16'h0000, 16'h0000, "R9");
        step(0, 0, 8'h12, 16'hFFFF, 16'hFFFF, "R9");

        // Back-to-back and mixed traffic (R8, R9).
        for (int n = 0; n < 600; n++) begin
            logic v = (n % 7 == 6) ? 1'b0 : 1'b1;
            step(v, logic'(n % 2), 8'($urandom), 16'($urandom), 16'($urandom), "R8");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule